// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with HI/LO Result Pair

This block runs integer multiply and divide over many cycles. It writes each result into two dedicated result registers, HI and LO, and never into a general destination register. A start command selects one of four operations: signed multiply, unsigned multiply, signed divide or unsigned divide. The same command supplies two 32-bit operands. A multiply leaves the 64-bit product split across HI (upper word) and LO (lower word). A divide leaves the quotient in LO and the remainder in HI. No operation raises an overflow or any other exception.

The pipeline reaches HI and LO through a read port and a write port. The read port returns a copy of either register. The write port loads either register from an operand. The `busy` output stays high while an operation is in flight. A read request is held off, with its ready signal low, until the result has been written, so the pipeline can stall a move-from on that one signal. The unit computes one quotient or product bit per cycle. It uses a shift-add multiplier and a restoring divider that work on operand magnitudes, and it fixes the signs in a final cycle.

Top module: `mdu_hilo`

## Requirements
- R1: After reset, HI and LO both read zero, `busy` is low, and `rdReady` follows `rdReq`.
- R2: A start sampled while idle raises `busy` on the next cycle. `busy` stays high for exactly 33 cycles, and HI/LO change on the same clock edge at which `busy` falls.
- R3: `startOp` = 2'b01 (unsigned multiply) leaves the 64-bit product of the operands, taken as natural numbers, with its upper word in HI and its lower word in LO.
- R4: `startOp` = 2'b00 (signed multiply) leaves the 64-bit two's complement product of the operands in HI:LO, including for operands of 0x80000000.
- R5: `startOp` = 2'b11 (unsigned divide) leaves the quotient in LO and the remainder in HI.
- R6: `startOp` = 2'b10 (signed divide) truncates the quotient toward zero into LO and puts a remainder with the sign of the dividend into HI. 0x80000000 divided by -1 gives LO = 0x80000000 and HI = 0, with no error indication.
- R7: `rdReady` is high exactly when `rdReq` is high and `busy` is low. While ready, `rdData` shows HI when `rdSel` = 1 and LO when `rdSel` = 0.
- R8: While idle, `wrEn` loads `wrData` into HI when `wrSel` = 1 and into LO when `wrSel` = 0. The value is readable on the next cycle.
- R9: A start asserted while `busy` is high is ignored. The running operation keeps its 33-cycle length and its result.
- R10: A divide with a zero divisor still completes after 33 busy cycles, and the unit then accepts moves and new commands normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Start an operation (accepted only while idle) |
| startOp | input | 2 | 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| opA | input | 32 | Multiplicand or dividend |
| opB | input | 32 | Multiplier or divisor |
| busy | output | 1 | Operation in flight |
| rdReq | input | 1 | Move-from request |
| rdSel | input | 1 | Read select: 1 HI, 0 LO |
| rdReady | output | 1 | Move-from can complete this cycle |
| rdData | output | 32 | Selected result register |
| wrEn | input | 1 | Move-to request (applied only while idle) |
| wrSel | input | 1 | Write select: 1 HI, 0 LO |
| wrData | input | 32 | Value for the move-to |

## Verification
A wrong step counter shows at once in the length of `busy`. The bench's model predicts the falling edge of `busy` to the cycle, so an error there is seen within 33 cycles of the start. A fault in the accumulator, in the magnitude conversion or in the final sign fix stays hidden while `busy` is high. It appears as a wrong HI or LO value on the first ready cycle after completion. `rdSel` alternates every cycle, so both registers are compared within two cycles of that point. A lost or spurious update of the result pair during a busy period appears only when the pair is next read.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  typedef enum logic [1:0] {
    OP_MULS = 2'b00,
    OP_MULU = 2'b01,
    OP_DIVS = 2'b10,
    OP_DIVU = 2'b11
  } mduOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // capture operands
    logic step;    // one iteration bit
    logic finish;  // sign fix and write HI/LO
  } mduStb_t;

endpackage

// File: rtl/mdu_ctrl.sv
module mdu_ctrl
  import mdu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    startValid,
  output mduStb_t stb,
  output logic    busyO
);

  localparam int CW = $clog2(W);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} state_e;

  state_e        state;
  logic [CW-1:0] stepCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      stepCnt <= '0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (startValid) begin
            state   <= S_RUN;
            stepCnt <= '0;
          end
        end
        S_RUN: begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == CW'(W - 1)) state <= S_FIN;
        end
        S_FIN: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.load   = (state == S_IDLE) && startValid;
    stb.step   = (state == S_RUN);
    stb.finish = (state == S_FIN);
    busyO      = (state != S_IDLE);
  end

  // R2
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyO) |-> $past(startValid));

  // R2
  fin_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_FIN) |=> !busyO);

endmodule

// File: rtl/mdu_dpath.sv
module mdu_dpath
  import mdu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  mduStb_t      stb,
  input  logic         busyIn,
  input  logic [1:0]   opSel,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         wrEn,
  input  logic         wrSel,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] hiO,
  output logic [W-1:0] loO
);

  localparam int PW = 2 * W;

  logic [W-1:0] hiReg, loReg;
  logic [W-1:0] accHi, accLo, mOp;
  logic         isDiv, negLo, negHi;

  logic         isSigned, signA, signB;
  logic [W-1:0] absA, absB;
  logic [W:0]   mulSum, divShift, divTrial;
  logic [PW-1:0] prodMag, prodFix;
  logic [W-1:0] quoFix, remFix;

  always_comb begin
    isSigned = ~opSel[0];
    signA    = isSigned & opA[W-1];
    signB    = isSigned & opB[W-1];
    absA     = signA ? (~opA + 1'b1) : opA;
    absB     = signB ? (~opB + 1'b1) : opB;

    mulSum   = {1'b0, accHi} + (accLo[0] ? {1'b0, mOp} : '0);
    divShift = {accHi, accLo[W-1]};
    divTrial = divShift - {1'b0, mOp};

    prodMag  = {accHi, accLo};
    prodFix  = negLo ? (~prodMag + 1'b1) : prodMag;
    quoFix   = negLo ? (~accLo + 1'b1) : accLo;
    remFix   = negHi ? (~accHi + 1'b1) : accHi;
  end

  // iteration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      accHi <= '0;
      accLo <= '0;
      mOp   <= '0;
      isDiv <= 1'b0;
      negLo <= 1'b0;
      negHi <= 1'b0;
    end else if (stb.load) begin
      accHi <= '0;
      accLo <= absA;
      mOp   <= absB;
      isDiv <= opSel[1];
      negLo <= signA ^ signB;
      negHi <= signA;
    end else if (stb.step) begin
      if (isDiv) begin
        if (!divTrial[W]) begin
          accHi <= divTrial[W-1:0];
          accLo <= {accLo[W-2:0], 1'b1};
        end else begin
          accHi <= divShift[W-1:0];
          accLo <= {accLo[W-2:0], 1'b0};
        end
      end else begin
        accHi <= mulSum[W:1];
        accLo <= {mulSum[0], accLo[W-1:1]};
      end
    end
  end

  // result pair
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiReg <= '0;
      loReg <= '0;
    end else if (stb.finish) begin
      if (isDiv) begin
        hiReg <= remFix;
        loReg <= quoFix;
      end else begin
        hiReg <= prodFix[PW-1:W];
        loReg <= prodFix[W-1:0];
      end
    end else if (!busyIn && wrEn) begin
      if (wrSel) hiReg <= wrData;
      else       loReg <= wrData;
    end
  end

  assign hiO = hiReg;
  assign loO = loReg;

  // R9
  hold_hilo_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busyIn && !stb.finish) |=> ($stable(hiReg) && $stable(loReg)));

  // R5
  rem_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isDiv && stb.step && (mOp != '0)) |=> (accHi < mOp));

endmodule

// File: rtl/mdu_hilo.sv
module mdu_hilo
  import mdu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         startValid,
  input  logic [1:0]   startOp,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic         busy,
  input  logic         rdReq,
  input  logic         rdSel,
  output logic         rdReady,
  output logic [W-1:0] rdData,
  input  logic         wrEn,
  input  logic         wrSel,
  input  logic [W-1:0] wrData
);

  mduStb_t      stb;
  logic         busyInt;
  logic [W-1:0] hiVal, loVal;

  mdu_ctrl #(.W(W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startValid(startValid),
    .stb       (stb),
    .busyO     (busyInt)
  );

  mdu_dpath #(.W(W)) u_dpath (
    .clk   (clk),
    .rstN  (rstN),
    .stb   (stb),
    .busyIn(busyInt),
    .opSel (startOp),
    .opA   (opA),
    .opB   (opB),
    .wrEn  (wrEn),
    .wrSel (wrSel),
    .wrData(wrData),
    .hiO   (hiVal),
    .loO   (loVal)
  );

  assign busy    = busyInt;
  assign rdReady = rdReq & ~busyInt;
  assign rdData  = rdSel ? hiVal : loVal;

  // R7
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && busyInt && !stb.finish) |=> !rdReady);

endmodule

// File: tb/mdu_hilo_tb.sv
`timescale 1ns/1ps
module mdu_hilo_tb;

  logic        clk = 1'b0;
  logic        rstN, startValid, rdReq, rdSel, wrEn, wrSel;
  logic [1:0]  startOp;
  logic [31:0] opA, opB, wrData;
  logic        busy, rdReady;
  logic [31:0] rdData;

  int    nRun = 0, nFail = 0;
  string tag = "R1";
  bit    checkOn = 1'b0;

  always #10 clk = ~clk;

  mdu_hilo u_dut (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startOp(startOp),
    .opA(opA), .opB(opB), .busy(busy), .rdReq(rdReq), .rdSel(rdSel),
    .rdReady(rdReady), .rdData(rdData), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData)
  );

  // behavioural reference
  logic [31:0] mHi, mLo;
  bit          hiOk, loOk, pendOk;
  int          mCnt;
  logic [63:0] mPend;

  function automatic logic [63:0] refResult(logic [1:0] op, logic [31:0] a, logic [31:0] b);
    longint sa, sb, q, r;
    logic [63:0] ua, ub;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    ua = {32'b0, a};
    ub = {32'b0, b};
    case (op)
      2'b00: return 64'(sa * sb);
      2'b01: return ua * ub;
      2'b10: begin
        if (sb == 0) return '0;
        q = sa / sb; r = sa % sb;
        return {r[31:0], q[31:0]};
      end
      default: begin
        if (b == 0) return '0;
        return {a % b, a / b};
      end
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mHi = '0; mLo = '0; hiOk = 1; loOk = 1; mCnt = 0;
    end else if (mCnt > 0) begin
      mCnt--;
      if (mCnt == 0) begin
        mHi = mPend[63:32]; mLo = mPend[31:0];
        hiOk = pendOk; loOk = pendOk;
      end
    end else begin
      if (startValid) begin
        mPend  = refResult(startOp, opA, opB);
        pendOk = !(startOp[1] && opB == 0);
        mCnt   = 33;
      end
      if (wrEn) begin
        if (wrSel) begin mHi = wrData; hiOk = 1; end
        else       begin mLo = wrData; loOk = 1; end
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (checkOn && rstN) begin
      chk("R2", 32'(busy), 32'(mCnt != 0));
      chk("R7", 32'(rdReady), 32'(rdReq && mCnt == 0));
      if (rdReq && mCnt == 0 && (rdSel ? hiOk : loOk))
        chk(tag, rdData, rdSel ? mHi : mLo);
    end
  end

  task automatic tick;
    @(posedge clk); #2;
    rdSel = ~rdSel;
  endtask

  task automatic waitIdle;
    while (mCnt != 0) tick;
    tick; tick; tick;
  endtask

  task automatic runOp(string t, logic [1:0] op, logic [31:0] a, logic [31:0] b);
    tag = t;
    startValid = 1; startOp = op; opA = a; opB = b;
    tick;
    startValid = 0;
    waitIdle;
  endtask

  task automatic moveTo(logic sel, logic [31:0] v);
    tag = "R8";
    wrEn = 1; wrSel = sel; wrData = v;
    tick;
    wrEn = 0;
    tick; tick;
  endtask

  initial begin
    #(20 * 150000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    int c;
    rstN = 0; startValid = 0; startOp = 0; opA = 0; opB = 0;
    rdReq = 1; rdSel = 0; wrEn = 0; wrSel = 0; wrData = 0;
    repeat (3) @(posedge clk);
    #2 rstN = 1;
    checkOn = 1;
    // R1: reset state
    @(negedge clk);
    chk("R1", 32'(busy), 0);
    chk("R1", 32'(rdReady), 1);
    tick; tick; tick;
    rdReq = 0; tick;
    chk("R1", 32'(rdReady), 0);
    rdReq = 1; tick;

    // R3 unsigned multiply
    runOp("R3", 2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    runOp("R3", 2'b01, 32'd12345, 32'd6789);
    runOp("R3", 2'b01, 32'h8000_0000, 32'd2);
    // R4 signed multiply
    runOp("R4", 2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    runOp("R4", 2'b00, -32'sd5, 32'sd7);
    runOp("R4", 2'b00, 32'h8000_0000, 32'h8000_0000);
    runOp("R4", 2'b00, 32'h8000_0000, 32'hFFFF_FFFF);
    // R5 unsigned divide
    runOp("R5", 2'b11, 32'd100, 32'd7);
    runOp("R5", 2'b11, 32'hFFFF_FFFF, 32'd3);
    runOp("R5", 2'b11, 32'd5, 32'd9);
    // R6 signed divide
    runOp("R6", 2'b10, -32'sd7, 32'sd2);
    runOp("R6", 2'b10, 32'sd7, -32'sd2);
    runOp("R6", 2'b10, -32'sd7, -32'sd2);
    runOp("R6", 2'b10, 32'h8000_0000, 32'hFFFF_FFFF);

    // R8 move-to
    moveTo(1'b1, 32'hDEAD_BEEF);
    moveTo(1'b0, 32'h1234_5678);

    // R2 exact busy length
    tag = "R2";
    startValid = 1; startOp = 2'b01; opA = 32'd3; opB = 32'd4;
    tick; startValid = 0;
    c = 0;
    while (busy && c < 100) begin c++; tick; end
    chk("R2", 32'(c), 32'd33);
    waitIdle;

    // R9 start while busy ignored
    tag = "R9";
    startValid = 1; startOp = 2'b11; opA = 32'd1000; opB = 32'd33;
    tick; startValid = 0;
    repeat (5) tick;
    startValid = 1; startOp = 2'b00; opA = 32'hFFFF_0000; opB = 32'd77;
    tick; startValid = 0;
    c = 6;
    while (busy && c < 100) begin c++; tick; end
    chk("R9", 32'(c), 32'd33);
    waitIdle;

    // R10 divide by zero completes
    tag = "R10";
    startValid = 1; startOp = 2'b10; opA = 32'd55; opB = 32'd0;
    tick; startValid = 0;
    c = 0;
    while (busy && c < 100) begin c++; tick; end
    chk("R10", 32'(c), 32'd33);
    waitIdle;
    moveTo(1'b1, 32'hA5A5_0001);
    moveTo(1'b0, 32'h5A5A_0002);
    runOp("R10", 2'b11, 32'd81, 32'd9);

    checkOn = 0;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule